// File: doc/BRIEF.md
# Malformed TLP Checker

This block runs the structural checks on a received PCI Express transaction layer packet once its header has been decoded. On a single-cycle `hdr_valid` strobe it takes the packet's format, type, length field, digest flag, traffic class, byte enables and in-page dword address. It also takes the message code, the payload dword count actually received, whether a digest was seen on the wire, the programmed maximum payload size code and the mask of initialized virtual channels.

Every rule is evaluated in parallel. One cycle after the strobe the block gives exactly one verdict. If the packet is clean it raises `pkt_deliver`. If it is malformed it raises `pkt_drop` together with a fatal uncorrectable error pulse, so the packet never reaches the application. A per-rule cause vector is also returned so the error logger can tell which rules tripped. Several rules may fail together.

Top module: `tlp_mal_chk`

## Requirements
- R1: Legal format/type pairs are the only accepted ones. Type 00000 takes any format with fmt[2]=0. Type 00001 takes formats 000 and 001. Types 00010, 00100, 00101, 01010 and 01011 take formats 000 and 010. Types 10xxx take formats 001 and 011. Every other pair sets cause bit 0.
- R2: The length field decodes with 0 meaning 1024 dwords. When fmt[1]=1 (with data), `rx_payload_dw` must equal the decoded length. When fmt[1]=0, `rx_payload_dw` must be 0. Any other value sets cause bit 1.
- R3: When fmt[1]=1 and the decoded length times 4 bytes exceeds 128 << `max_pl_code`, cause bit 2 is set. Codes 6 and 7 are treated as 4096 bytes.
- R4: When `hdr_td` differs from `rx_digest`, cause bit 3 is set.
- R5: Byte-enable rules apply to types 00000, 00001, 00010, 00100 and 00101. For a decoded length of 1, the last byte enable must be 0000. For a longer length, both byte enables must be nonzero. A violation sets cause bit 4.
- R6: For types 00000 and 00001, if `hdr_addr_dw` plus the decoded length exceeds 1024, cause bit 5 is set because the access crosses a 4 KB page.
- R7: For a message (type 10xxx) with a nonzero traffic class, cause bit 6 is set if the code belongs to one of these groups:
  - Unlock: 0x00.
  - Power management: 0x14, 0x18, 0x19, 0x1B.
  - Interrupt assert/deassert: 0x20–0x27.
  - Error signaling: 0x30, 0x31, 0x33.
  - Slot power limit: 0x50.
- R8: When bit `vc_id` of `vc_init_mask` is 0, cause bit 7 is set.
- R9: In the cycle after a strobe, exactly one of `pkt_deliver` and `pkt_drop` is high. `pkt_drop` is high exactly when some cause bit is set, and `fatal_err` equals `pkt_drop`.
- R10: `err_cause` is all zero whenever `pkt_drop` is low.
- R11: While reset is asserted and after it is released, all outputs are low until the first strobe has been registered.
- R12: A cycle with no strobe produces no verdict: all outputs are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | One-cycle strobe: header fields are valid |
| hdr_fmt | input | 3 | Format field |
| hdr_type | input | 5 | Type field |
| hdr_len | input | LEN_W | Length field in dwords (0 = 1024) |
| hdr_td | input | 1 | Digest-present flag from the header |
| hdr_tc | input | 3 | Traffic class |
| hdr_first_be | input | 4 | First dword byte enables |
| hdr_last_be | input | 4 | Last dword byte enables |
| hdr_addr_dw | input | 10 | Address bits 11:2 (dword offset in 4 KB page) |
| hdr_msg_code | input | 8 | Message code (messages only) |
| rx_payload_dw | input | LEN_W+1 | Payload dwords actually received |
| rx_digest | input | 1 | A digest dword was received |
| max_pl_code | input | 3 | Maximum payload size code |
| vc_id | input | VC_W | Virtual channel the packet maps to |
| vc_init_mask | input | NUM_VC | One bit per initialized virtual channel |
| pkt_deliver | output | 1 | Packet is clean and may go to the application |
| pkt_drop | output | 1 | Packet is malformed and removed |
| fatal_err | output | 1 | Fatal uncorrectable error pulse |
| err_cause | output | 8 | Per-rule failure bits (bit numbers as in R1–R8) |

## Verification
The assertions assume three things about the inputs:
- `hdr_valid` is a single-cycle strobe.
- Every header field is settled in the strobe cycle.
- `vc_id` indexes an existing bit of `vc_init_mask`.

The stimulus drives fields and strobe at the falling edge, drops the strobe after one cycle, and keeps `vc_id` within the eight channels of the default configuration. Each sweep holds every field outside the rule under test at a clean value. This means each expected cause vector isolates that rule, except where a sweep crosses rules on purpose (length against payload limit).

// File: rtl/tlp_mal_pkg.sv
package tlp_mal_pkg;

    localparam int CAUSE_W   = 8;
    localparam int C_FMTTYPE = 0;
    localparam int C_LENGTH  = 1;
    localparam int C_PAYLOAD = 2;
    localparam int C_DIGEST  = 3;
    localparam int C_BYTEEN  = 4;
    localparam int C_PAGE4K  = 5;
    localparam int C_MSGTC   = 6;
    localparam int C_VCINIT  = 7;

    typedef struct packed {
        logic               deliver;
        logic               drop;
        logic               fatal;
        logic [CAUSE_W-1:0] cause;
    } verdict_t;

    // Length field of 0 stands for the largest count.
    function automatic logic [10:0] decode_len(input logic [9:0] f);
        return (f == 10'd0) ? 11'd1024 : {1'b0, f};
    endfunction

endpackage

// File: rtl/tlp_mal_fmt_chk.sv
module tlp_mal_fmt_chk (
    input  logic [2:0] fmt,
    input  logic [4:0] typ,
    output logic       fmt_bad,
    output logic       is_mem,
    output logic       has_be,
    output logic       is_msg
);
    logic legal;

    always_comb begin
        legal = 1'b0;
        unique casez (typ)
            5'b00000:                   legal = (fmt[2] == 1'b0);
            5'b00001:                   legal = (fmt == 3'b000) || (fmt == 3'b001);
            5'b00010, 5'b00100,
            5'b00101, 5'b01010,
            5'b01011:                   legal = (fmt == 3'b000) || (fmt == 3'b010);
            5'b10???:                   legal = (fmt == 3'b001) || (fmt == 3'b011);
            default:                    legal = 1'b0;
        endcase
    end

    assign fmt_bad = ~legal;
    assign is_mem  = (typ == 5'b00000) || (typ == 5'b00001);
    assign has_be  = is_mem || (typ == 5'b00010) || (typ == 5'b00100) || (typ == 5'b00101);
    assign is_msg  = (typ[4:3] == 2'b10);
endmodule

// File: rtl/tlp_mal_len_chk.sv
module tlp_mal_len_chk
    import tlp_mal_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             has_data,
    input  logic             is_mem,
    input  logic             has_be,
    input  logic [LEN_W-1:0] len_f,
    input  logic [LEN_W:0]   rx_dw,
    input  logic [2:0]       mps_code,
    input  logic [3:0]       first_be,
    input  logic [3:0]       last_be,
    input  logic [9:0]       addr_dw,
    output logic             len_bad,
    output logic             mps_bad,
    output logic             be_bad,
    output logic             page_bad
);
    localparam logic [10:0] MIN_MPS_DW = 11'd32;
    localparam logic [11:0] PAGE_DW    = 12'd1024;

    logic [10:0] dlen;
    logic [2:0]  eff_code;
    logic [10:0] mps_dw;
    logic [11:0] end_dw;

    always_comb begin
        dlen     = decode_len(len_f);
        eff_code = (mps_code > 3'd5) ? 3'd5 : mps_code;
        mps_dw   = MIN_MPS_DW << eff_code;
        end_dw   = {2'b00, addr_dw} + {1'b0, dlen};

        len_bad  = has_data ? ({{(11-LEN_W-1){1'b0}}, rx_dw} != dlen) : (rx_dw != '0);
        mps_bad  = has_data && (dlen > mps_dw);
        if (dlen == 11'd1)
            be_bad = has_be && (last_be != 4'b0000);
        else
            be_bad = has_be && ((first_be == 4'b0000) || (last_be == 4'b0000));
        page_bad = is_mem && (end_dw > PAGE_DW);
    end
endmodule

// File: rtl/tlp_mal_route_chk.sv
module tlp_mal_route_chk #(
    parameter int NUM_VC = 8,
    parameter int VC_W   = 3
) (
    input  logic              td,
    input  logic              digest,
    input  logic              is_msg,
    input  logic [7:0]        msg_code,
    input  logic [2:0]        tc,
    input  logic [VC_W-1:0]   vc_id,
    input  logic [NUM_VC-1:0] vc_mask,
    output logic              dig_bad,
    output logic              tc_bad,
    output logic              vc_bad
);
    logic              tc0_only;
    logic [NUM_VC-1:0] vc_hit;

    always_comb begin
        unique casez (msg_code)
            8'h00, 8'h14, 8'h18, 8'h19, 8'h1B,
            8'b0010_0???, 8'h30, 8'h31, 8'h33,
            8'h50:   tc0_only = 1'b1;
            default: tc0_only = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
        assign vc_hit[g] = (vc_id == VC_W'(g)) && vc_mask[g];
    end

    assign dig_bad = td ^ digest;
    assign tc_bad  = is_msg && tc0_only && (tc != 3'd0);
    assign vc_bad  = ~|vc_hit;
endmodule

// File: rtl/tlp_mal_chk.sv
module tlp_mal_chk
    import tlp_mal_pkg::*;
#(
    parameter int LEN_W  = 10,
    parameter int NUM_VC = 8,
    localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_valid,
    input  logic [2:0]        hdr_fmt,
    input  logic [4:0]        hdr_type,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic              hdr_td,
    input  logic [2:0]        hdr_tc,
    input  logic [3:0]        hdr_first_be,
    input  logic [3:0]        hdr_last_be,
    input  logic [9:0]        hdr_addr_dw,
    input  logic [7:0]        hdr_msg_code,
    input  logic [LEN_W:0]    rx_payload_dw,
    input  logic              rx_digest,
    input  logic [2:0]        max_pl_code,
    input  logic [VC_W-1:0]   vc_id,
    input  logic [NUM_VC-1:0] vc_init_mask,
    output logic              pkt_deliver,
    output logic              pkt_drop,
    output logic              fatal_err,
    output logic [CAUSE_W-1:0] err_cause
);
    logic fmt_bad, is_mem, has_be, is_msg;
    logic len_bad, mps_bad, be_bad, page_bad;
    logic dig_bad, tc_bad, vc_bad;
    logic [CAUSE_W-1:0] cause_w;
    verdict_t st_d, st_q;

    tlp_mal_fmt_chk u_fmt (
        .fmt     (hdr_fmt),
        .typ     (hdr_type),
        .fmt_bad (fmt_bad),
        .is_mem  (is_mem),
        .has_be  (has_be),
        .is_msg  (is_msg)
    );

    tlp_mal_len_chk #(.LEN_W(LEN_W)) u_len (
        .has_data (hdr_fmt[1]),
        .is_mem   (is_mem),
        .has_be   (has_be),
        .len_f    (hdr_len),
        .rx_dw    (rx_payload_dw),
        .mps_code (max_pl_code),
        .first_be (hdr_first_be),
        .last_be  (hdr_last_be),
        .addr_dw  (hdr_addr_dw),
        .len_bad  (len_bad),
        .mps_bad  (mps_bad),
        .be_bad   (be_bad),
        .page_bad (page_bad)
    );

    tlp_mal_route_chk #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_route (
        .td       (hdr_td),
        .digest   (rx_digest),
        .is_msg   (is_msg),
        .msg_code (hdr_msg_code),
        .tc       (hdr_tc),
        .vc_id    (vc_id),
        .vc_mask  (vc_init_mask),
        .dig_bad  (dig_bad),
        .tc_bad   (tc_bad),
        .vc_bad   (vc_bad)
    );

    always_comb begin
        cause_w            = '0;
        cause_w[C_FMTTYPE] = fmt_bad;
        cause_w[C_LENGTH]  = len_bad;
        cause_w[C_PAYLOAD] = mps_bad;
        cause_w[C_DIGEST]  = dig_bad;
        cause_w[C_BYTEEN]  = be_bad;
        cause_w[C_PAGE4K]  = page_bad;
        cause_w[C_MSGTC]   = tc_bad;
        cause_w[C_VCINIT]  = vc_bad;

        st_d = '0;
        if (hdr_valid) begin
            st_d.cause   = cause_w;
            st_d.drop    = |cause_w;
            st_d.fatal   = |cause_w;
            st_d.deliver = ~|cause_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pkt_deliver = st_q.deliver;
    assign pkt_drop    = st_q.drop;
    assign fatal_err   = st_q.fatal;
    assign err_cause   = st_q.cause;
endmodule

// File: rtl/tlp_mal_chk_sva.sv
module tlp_mal_chk_sva #(
    parameter int NUM_VC = 8,
    parameter int VC_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hdr_valid,
    input logic [2:0]        hdr_fmt,
    input logic              hdr_td,
    input logic [10:0]       rx_payload_dw,
    input logic              rx_digest,
    input logic [VC_W-1:0]   vc_id,
    input logic [NUM_VC-1:0] vc_init_mask,
    input logic              pkt_deliver,
    input logic              pkt_drop,
    input logic              fatal_err,
    input logic [7:0]        err_cause
);
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_deliver && pkt_drop)); // R9
    AST_FATAL_TRACKS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_err == pkt_drop); // R9
    AST_DROP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_drop |-> (err_cause != 8'd0)); // R9
    AST_QUIET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_drop |-> (err_cause == 8'd0)); // R10
    AST_NO_STROBE_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !(pkt_deliver || pkt_drop)); // R12
    AST_STROBE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> (pkt_deliver || pkt_drop)); // R9
    AST_DIGEST_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (hdr_td != rx_digest)) |=> (pkt_drop && err_cause[3])); // R4
    AST_NODATA_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !hdr_fmt[1] && (rx_payload_dw != 11'd0)) |=> err_cause[1]); // R2
    AST_VC_UNINIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !vc_init_mask[vc_id]) |=> err_cause[7]); // R8
endmodule

bind tlp_mal_chk tlp_mal_chk_sva #(.NUM_VC(NUM_VC), .VC_W(VC_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .hdr_valid     (hdr_valid),
    .hdr_fmt       (hdr_fmt),
    .hdr_td        (hdr_td),
    .rx_payload_dw (11'(rx_payload_dw)),
    .rx_digest     (rx_digest),
    .vc_id         (vc_id),
    .vc_init_mask  (vc_init_mask),
    .pkt_deliver   (pkt_deliver),
    .pkt_drop      (pkt_drop),
    .fatal_err     (fatal_err),
    .err_cause     (err_cause)
);

// File: tb/tlp_mal_chk_tb_top.sv
`timescale 1ns/1ps
module tlp_mal_chk_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [2:0]  fmt = '0;
    logic [4:0]  typ = '0;
    logic [9:0]  len = 10'd1;
    logic        td = 1'b0;
    logic [2:0]  tc = '0;
    logic [3:0]  fbe = 4'hF;
    logic [3:0]  lbe = 4'h0;
    logic [9:0]  addr = '0;
    logic [7:0]  mcode = 8'h7E;
    logic [10:0] rxdw = '0;
    logic        dig = 1'b0;
    logic [2:0]  mps = 3'd5;
    logic [2:0]  vc = '0;
    logic [7:0]  vmask = 8'hFF;
    logic        deliver, drop, fatal;
    logic [7:0]  cause;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tlp_mal_chk dut_i (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid),
        .hdr_fmt(fmt), .hdr_type(typ), .hdr_len(len), .hdr_td(td),
        .hdr_tc(tc), .hdr_first_be(fbe), .hdr_last_be(lbe),
        .hdr_addr_dw(addr), .hdr_msg_code(mcode), .rx_payload_dw(rxdw),
        .rx_digest(dig), .max_pl_code(mps), .vc_id(vc), .vc_init_mask(vmask),
        .pkt_deliver(deliver), .pkt_drop(drop), .fatal_err(fatal), .err_cause(cause)
    );

    function automatic int dlen();
        return (len == 10'd0) ? 1024 : int'(len);
    endfunction

    function automatic logic [7:0] model();
        logic [7:0] e = '0;
        int L = dlen();
        int cap;
        logic legal, tc0;
        case (typ)
            5'd0:  legal = (fmt < 3'd4);
            5'd1:  legal = (fmt == 3'd0 || fmt == 3'd1);
            5'd2, 5'd4, 5'd5, 5'd10, 5'd11: legal = (fmt == 3'd0 || fmt == 3'd2);
            default: legal = (typ >= 5'd16 && typ <= 5'd23) && (fmt == 3'd1 || fmt == 3'd3);
        endcase
        e[0] = !legal;
        e[1] = fmt[1] ? (int'(rxdw) != L) : (rxdw != 0);
        cap  = 128 << ((mps > 3'd5) ? 5 : int'(mps));
        e[2] = fmt[1] && (L * 4 > cap);
        e[3] = (td != dig);
        if (typ == 5'd0 || typ == 5'd1 || typ == 5'd2 || typ == 5'd4 || typ == 5'd5)
            e[4] = (L == 1) ? (lbe != 0) : (fbe == 0 || lbe == 0);
        e[5] = (typ == 5'd0 || typ == 5'd1) && (int'(addr) + L > 1024);
        tc0  = (mcode == 8'h00) || (mcode == 8'h14) || (mcode == 8'h18) ||
               (mcode == 8'h19) || (mcode == 8'h1B) ||
               (mcode >= 8'h20 && mcode <= 8'h27) ||
               (mcode == 8'h30) || (mcode == 8'h31) || (mcode == 8'h33) ||
               (mcode == 8'h50);
        e[6] = (typ >= 5'd16 && typ <= 5'd23) && tc0 && (tc != 0);
        e[7] = !vmask[vc];
        return e;
    endfunction

    task automatic fire(input string tag);
        logic [7:0] e = model();
        logic ed = |e;
        @(negedge clk) hdr_valid = 1'b1;
        @(negedge clk) hdr_valid = 1'b0;
        checks++;
        if (drop !== ed || deliver !== !ed || fatal !== ed || cause !== e) begin
            failures++;
            $display("FAIL %s: drop=%0b deliver=%0b fatal=%0b cause=%b expected drop=%0b cause=%b",
                     tag, drop, deliver, fatal, cause, ed, e);
        end
    endtask

    task automatic idle_check(input string tag);
        checks++;
        if (deliver !== 1'b0 || drop !== 1'b0 || fatal !== 1'b0 || cause !== 8'd0) begin
            failures++;
            $display("FAIL %s: outputs deliver=%0b drop=%0b fatal=%0b cause=%b expected all zero",
                     tag, deliver, drop, fatal, cause);
        end
    endtask

    task automatic clean();
        fmt = 3'd0; typ = 5'd0; len = 10'd1; td = 0; dig = 0; tc = 0;
        fbe = 4'hF; lbe = 4'h0; addr = 0; mcode = 8'h7E; rxdw = 0;
        mps = 3'd5; vc = 0; vmask = 8'hFF;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete, expected end of stimulus");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R11 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_check("R11 after reset");

        // R1: every format/type pair, all else clean
        for (int f = 0; f < 8; f++) begin
            for (int t = 0; t < 32; t++) begin
                clean();
                fmt = f[2:0]; typ = t[4:0];
                rxdw = fmt[1] ? 11'd1 : 11'd0;
                fire("R1 fmt/type");
            end
        end

        // R3 with R2: memory write lengths against every payload code
        for (int c = 0; c < 8; c++) begin
            for (int l = 0; l < 1024; l += 7) begin
                clean();
                fmt = 3'd2; mps = c[2:0]; len = l[9:0];
                rxdw = 11'(dlen());
                lbe = (dlen() == 1) ? 4'h0 : 4'hF;
                fire("R3 payload limit");
            end
            clean(); fmt = 3'd2; mps = c[2:0]; len = 10'd0; rxdw = 11'd1024; lbe = 4'hF;
            fire("R3 length 0 is 1024");
        end

        // R2: received count off by one, and data on a no-data format
        for (int l = 1; l < 40; l += 3) begin
            clean(); fmt = 3'd2; len = l[9:0]; lbe = (l == 1) ? 4'h0 : 4'h3;
            rxdw = 11'(l + 1); fire("R2 long");
            rxdw = 11'(l - 1); fire("R2 short");
            fmt = 3'd0; rxdw = 11'(l); fire("R2 no-data with payload");
        end

        // R4: digest flag versus digest seen
        for (int k = 0; k < 4; k++) begin
            clean(); td = k[0]; dig = k[1];
            fire("R4 digest");
        end

        // R5: all byte enables on a memory read, lengths 1, 2, 1024, and a completion
        for (int lsel = 0; lsel < 3; lsel++) begin
            for (int b = 0; b < 256; b++) begin
                clean();
                len = (lsel == 0) ? 10'd1 : (lsel == 1) ? 10'd2 : 10'd0;
                fbe = b[3:0]; lbe = b[7:4];
                fire("R5 byte enables");
            end
        end
        for (int b = 0; b < 16; b++) begin
            clean(); typ = 5'd10; fmt = 3'd2; rxdw = 11'd2; len = 10'd2;
            fbe = 4'h0; lbe = b[3:0];
            fire("R5 completion exempt");
        end

        // R6: page crossing for memory and non-memory requests
        for (int a = 0; a < 1024; a += 31) begin
            for (int ls = 0; ls < 4; ls++) begin
                clean();
                addr = a[9:0];
                len = (ls == 0) ? 10'd1 : (ls == 1) ? 10'd16 : (ls == 2) ? 10'd500 : 10'd0;
                lbe = (len == 10'd1) ? 4'h0 : 4'hF;
                fire("R6 4KB page");
            end
        end
        clean(); addr = 10'd1023; len = 10'd1; fire("R6 last dword fits");
        clean(); addr = 10'd1023; len = 10'd2; lbe = 4'hF; fire("R6 one past");
        clean(); typ = 5'd2; addr = 10'd1023; len = 10'd2; lbe = 4'hF; fire("R6 io exempt");

        // R7: every message code on TC0 and TC5
        for (int m = 0; m < 256; m++) begin
            for (int tsel = 0; tsel < 2; tsel++) begin
                clean();
                fmt = 3'd1; typ = 5'd20; mcode = m[7:0]; tc = (tsel == 0) ? 3'd0 : 3'd5;
                fbe = 4'h0; lbe = 4'hF;
                fire("R7 message traffic class");
            end
        end

        // R8: virtual channel against init masks
        for (int v = 0; v < 8; v++) begin
            for (int p = 0; p < 4; p++) begin
                clean();
                vc = v[2:0];
                vmask = (p == 0) ? 8'hFF : (p == 1) ? 8'h01 : (p == 2) ? 8'hA5 : 8'h00;
                fire("R8 vc init");
            end
        end

        // R9: multiple failures together
        clean(); td = 1; vmask = 8'h00; fmt = 3'd5; fire("R9 several causes");

        // R12: no strobe, no verdict
        clean(); td = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            idle_check("R12 idle");
        end
        clean(); fire("R10 clean deliver");
        @(negedge clk);
        idle_check("R12 after verdict");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule